// File: doc/BRIEF.md
# Processor Low-Power Mode Sequencer

This controller moves a processor core from full-power operation into one of three reduced-power states (doze, nap, sleep) and back out again. Software picks the target state ahead of time by writing a one-hot configuration field. Entry starts only when a separate power-enable bit is set, so programming the mode does nothing by itself. Doze is entered at once. Nap and sleep first pass through a quiescing state that holds the core until the bus reports that no transaction is outstanding.

Three wake inputs bring the core back to full power: the external interrupt, the system-management interrupt and the machine-check input. A soft reset or a hard reset does the same. While the core sleeps, system logic is told that it may stop the PLL and the reference clock. If system logic reports that it stopped the PLL, a wake first starts a relock wait. The wait is counted in reference-clock cycles and derived from the clock frequency and the relock time in microseconds. Full power returns only when the wait is over.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While hard reset `rst_n` is low, and on its release, the block shows status 0 (full), `pow_en` is 0, both clock enables are 1, and `quiesce_req` and `pll_may_stop` are 0.
- R2: Changing `mode_cfg` while `pow_en` is 0 causes no transition. A set `pow_en` with a `mode_cfg` value that does not have exactly one bit set (bit0 doze, bit1 nap, bit2 sleep) also leaves the block in full.
- R3: When the block is in full, `pow_en` is 1, the mode is doze and no wake is present, the next cycle shows status 1 (doze), whatever `bus_busy` is. In doze `core_clk_en` is 0 and `snoop_clk_en` is 1.
- R4: When nap or sleep is requested the same way, the block goes to status 4 (quiescing) with `quiesce_req` and both clock enables at 1. It stays there while `bus_busy` is 1. In the cycle after the first low `bus_busy`, it shows status 2 (nap) or status 3 (sleep). Both clock enables are 0 in nap and in sleep, and `pll_may_stop` is 1 only in sleep.
- R5: Any of `wake_int`, `wake_smi` or `wake_mcp` returns the block to status 0 in the next cycle. This holds from doze, from nap, from quiescing, and from sleep while `pll_stopped` is 0.
- R6: A wake in sleep while `pll_stopped` is 1 gives status 5 (relock) with both clock enables at 0. The relock lasts exactly CLK_MHZ*RELOCK_US cycles (at least 1), and status 0 follows. Wake inputs during relock do not shorten it.
- R7: A wake clears `pow_en` in the next cycle. If `pow_set` and a wake arrive in the same cycle, `pow_en` stays 0 and the block stays in full. `pow_set` alone sets `pow_en` in the next cycle.
- R8: `soft_rst` returns the block to status 0 with `pow_en` at 0 in the next cycle, from any state.
- R9: Driving `rst_n` low in any state returns the outputs to the R1 values without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset, synchronous |
| mode_cfg | input | 3 | One-hot target mode: bit0 doze, bit1 nap, bit2 sleep |
| pow_set | input | 1 | Pulse that sets the power-enable bit |
| bus_busy | input | 1 | Bus transaction outstanding |
| wake_int | input | 1 | External interrupt wake |
| wake_smi | input | 1 | System-management interrupt wake |
| wake_mcp | input | 1 | Machine-check wake |
| pll_stopped | input | 1 | System logic reports the PLL was stopped during sleep |
| pow_en | output | 1 | Power-enable bit |
| core_clk_en | output | 1 | Core clock enable |
| snoop_clk_en | output | 1 | Snoop logic clock enable |
| quiesce_req | output | 1 | Request to drain the bus |
| pll_may_stop | output | 1 | PLL and reference clock may be stopped |
| status | output | 3 | 0 full, 1 doze, 2 nap, 3 sleep, 4 quiescing, 5 relock |

## Verification
The bench keeps `bus_busy` high for several cycles during quiescing. A design that ignored it would reach nap or sleep early, and one that waited for it in doze would never reach doze. It puts a wake in the same cycle as `pow_set`, and it leaves `pow_en` set under an invalid mode. A design with the wrong priority, or one that started on any mode bit, would leave full. The length of the relock is compared cycle by cycle, so an off-by-one counter shows up as early or late status 0. Soft reset and hard reset are applied while quiescing, sleeping and napping, to catch a state or bit that is not cleared.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    PMC_FULL    = 3'd0,
    PMC_DOZE    = 3'd1,
    PMC_NAP     = 3'd2,
    PMC_SLEEP   = 3'd3,
    PMC_QUIESCE = 3'd4,
    PMC_RELOCK  = 3'd5
  } pmc_state_e;

  localparam int MODE_W = 3;

  // Relock wait in reference-clock cycles, never below one.
  function automatic int relock_cycles(input int mhz, input int us);
    int c;
    c = mhz * us;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic logic is_one_hot(input logic [MODE_W-1:0] m);
    return (m != '0) && ((m & (m - 1'b1)) == '0);
  endfunction

  function automatic logic core_clock_on(input pmc_state_e s);
    return (s == PMC_FULL) || (s == PMC_QUIESCE);
  endfunction

  function automatic logic snoop_clock_on(input pmc_state_e s);
    return (s == PMC_FULL) || (s == PMC_QUIESCE) || (s == PMC_DOZE);
  endfunction

endpackage

// File: rtl/pmc_mode_decode.sv
module pmc_mode_decode
  import pmc_pkg::*;
(
  input  logic [MODE_W-1:0] mode_cfg,
  output logic              mode_valid,
  output logic              mode_doze,
  output pmc_state_e        deep_target
);
  always_comb begin
    mode_valid  = is_one_hot(mode_cfg);
    mode_doze   = mode_cfg[0];
    deep_target = mode_cfg[2] ? PMC_SLEEP : PMC_NAP;
  end
endmodule

// File: rtl/pmc_relock_timer.sv
module pmc_relock_timer #(
  parameter int LIMIT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
    else          cnt <= '0;
  end

  assign done = run && (cnt == LAST);
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       wake_any,
  input  logic       pow_en,
  input  logic       mode_valid,
  input  logic       mode_doze,
  input  pmc_state_e deep_target,
  input  logic       bus_busy,
  input  logic       pll_stopped,
  input  logic       relock_done,
  output pmc_state_e state
);
  pmc_state_e nxt, tgt, tgt_nxt;

  always_comb begin
    nxt     = state;
    tgt_nxt = tgt;
    if (soft_rst) begin
      nxt = PMC_FULL;
    end else begin
      unique case (state)
        PMC_FULL: if (pow_en && mode_valid && !wake_any) begin
          if (mode_doze) nxt = PMC_DOZE;
          else begin
            nxt     = PMC_QUIESCE;
            tgt_nxt = deep_target;
          end
        end
        PMC_QUIESCE: if (wake_any) nxt = PMC_FULL;
                     else if (!bus_busy) nxt = tgt;
        PMC_DOZE, PMC_NAP: if (wake_any) nxt = PMC_FULL;
        PMC_SLEEP: if (wake_any) nxt = pll_stopped ? PMC_RELOCK : PMC_FULL;
        PMC_RELOCK: if (relock_done) nxt = PMC_FULL;
        default: nxt = PMC_FULL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PMC_FULL;
      tgt   <= PMC_NAP;
    end else begin
      state <= nxt;
      tgt   <= tgt_nxt;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int RELOCK_US = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic [2:0] mode_cfg,
  input  logic       pow_set,
  input  logic       bus_busy,
  input  logic       wake_int,
  input  logic       wake_smi,
  input  logic       wake_mcp,
  input  logic       pll_stopped,
  output logic       pow_en,
  output logic       core_clk_en,
  output logic       snoop_clk_en,
  output logic       quiesce_req,
  output logic       pll_may_stop,
  output logic [2:0] status
);
  localparam int RELOCK_CYC = relock_cycles(CLK_MHZ, RELOCK_US);

  logic       wake_any;
  logic       mode_valid, mode_doze, relock_done;
  pmc_state_e deep_target, state;

  assign wake_any = wake_int | wake_smi | wake_mcp;

  // Wake and soft reset take priority over the set pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pow_en <= 1'b0;
    else if (soft_rst || wake_any) pow_en <= 1'b0;
    else if (pow_set)             pow_en <= 1'b1;
  end

  pmc_mode_decode u_dec (
    .mode_cfg   (mode_cfg),
    .mode_valid (mode_valid),
    .mode_doze  (mode_doze),
    .deep_target(deep_target)
  );

  pmc_relock_timer #(.LIMIT(RELOCK_CYC)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state == PMC_RELOCK),
    .done (relock_done)
  );

  pmc_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .wake_any   (wake_any),
    .pow_en     (pow_en),
    .mode_valid (mode_valid),
    .mode_doze  (mode_doze),
    .deep_target(deep_target),
    .bus_busy   (bus_busy),
    .pll_stopped(pll_stopped),
    .relock_done(relock_done),
    .state      (state)
  );

  assign core_clk_en  = core_clock_on(state);
  assign snoop_clk_en = snoop_clock_on(state);
  assign quiesce_req  = (state == PMC_QUIESCE);
  assign pll_may_stop = (state == PMC_SLEEP);
  assign status       = state;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       wake_any,
  input logic       pow_en,
  input logic       bus_busy,
  input logic       pll_stopped,
  input logic       core_clk_en,
  input logic       snoop_clk_en,
  input logic       quiesce_req,
  input logic [2:0] status
);
  AST_NO_TRIGGER_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd0 && !pow_en) |=> (status == 3'd0)); // R2

  AST_QUIESCE_HOLDS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd4 && bus_busy && !wake_any && !soft_rst) |=> (status == 3'd4)); // R4

  AST_QUIESCE_KEEPS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    quiesce_req |-> core_clk_en); // R4

  AST_WAKE_LIGHT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == 3'd1 || status == 3'd2) && wake_any) |=> (status == 3'd0)); // R5

  AST_SLEEP_TO_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd3 && wake_any && pll_stopped && !soft_rst) |=> (status == 3'd5)); // R6

  AST_RELOCK_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd5) |-> (!core_clk_en && !snoop_clk_en)); // R6

  AST_WAKE_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    wake_any |=> !pow_en); // R7

  AST_SOFT_RESET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status == 3'd0 && !pow_en)); // R8
endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst    (soft_rst),
  .wake_any    (wake_any),
  .pow_en      (pow_en),
  .bus_busy    (bus_busy),
  .pll_stopped (pll_stopped),
  .core_clk_en (core_clk_en),
  .snoop_clk_en(snoop_clk_en),
  .quiesce_req (quiesce_req),
  .status      (status)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int T_MHZ = 4;
  localparam int T_US  = 3;
  localparam int RELOCK_LEN = 12; // 4 MHz times 3 us

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, pow_set = 1'b0, bus_busy = 1'b0;
  logic wake_int = 1'b0, wake_smi = 1'b0, wake_mcp = 1'b0, pll_stopped = 1'b0;
  logic [2:0] mode_cfg = 3'b000;
  logic pow_en, core_clk_en, snoop_clk_en, quiesce_req, pll_may_stop;
  logic [2:0] status;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string req = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.CLK_MHZ(T_MHZ), .RELOCK_US(T_US)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .mode_cfg(mode_cfg),
    .pow_set(pow_set), .bus_busy(bus_busy), .wake_int(wake_int),
    .wake_smi(wake_smi), .wake_mcp(wake_mcp), .pll_stopped(pll_stopped),
    .pow_en(pow_en), .core_clk_en(core_clk_en), .snoop_clk_en(snoop_clk_en),
    .quiesce_req(quiesce_req), .pll_may_stop(pll_may_stop), .status(status)
  );

  // Behavioural reference: mode names as integers, relock as a down-counter.
  int ms = 0, target = 2, left = 0;
  bit mp = 0;

  always @(posedge clk or negedge rst_n) begin
    bit w, ok;
    if (!rst_n) begin
      ms = 0; mp = 0; left = 0;
    end else begin
      w  = wake_int || wake_smi || wake_mcp;
      ok = (mode_cfg == 3'b001) || (mode_cfg == 3'b010) || (mode_cfg == 3'b100);
      if (soft_rst) begin
        ms = 0; mp = 0;
      end else begin
        if (ms == 0) begin
          if (mp && ok && !w) begin
            if (mode_cfg == 3'b001) ms = 1;
            else begin ms = 4; target = (mode_cfg == 3'b100) ? 3 : 2; end
          end
        end else if (ms == 4) begin
          if (w) ms = 0; else if (!bus_busy) ms = target;
        end else if (ms == 1 || ms == 2) begin
          if (w) ms = 0;
        end else if (ms == 3) begin
          if (w && pll_stopped) begin ms = 5; left = RELOCK_LEN; end
          else if (w) ms = 0;
        end else if (ms == 5) begin
          left = left - 1;
          if (left == 0) ms = 0;
        end
        if (w) mp = 0; else if (pow_set) mp = 1;
      end
    end
  end

  task automatic check(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      check("status", int'(status), ms);
      check("pow_en", int'(pow_en), int'(mp));
      check("core_clk_en", int'(core_clk_en), (ms == 0 || ms == 4) ? 1 : 0);
      check("snoop_clk_en", int'(snoop_clk_en), (ms == 0 || ms == 4 || ms == 1) ? 1 : 0);
      check("quiesce_req", int'(quiesce_req), (ms == 4) ? 1 : 0);
      check("pll_may_stop", int'(pll_may_stop), (ms == 3) ? 1 : 0);
      if (cycles > 20000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_set();
    pow_set = 1'b1; wait_cyc(1); pow_set = 1'b0;
  endtask

  task automatic pulse_wake(int which);
    if (which == 0) wake_int = 1'b1;
    else if (which == 1) wake_smi = 1'b1;
    else wake_mcp = 1'b1;
    wait_cyc(1);
    wake_int = 1'b0; wake_smi = 1'b0; wake_mcp = 1'b0;
  endtask

  task automatic pulse_soft();
    soft_rst = 1'b1; wait_cyc(1); soft_rst = 1'b0;
  endtask

  initial begin
    req = "R1"; wait_cyc(3); rst_n = 1'b1; wait_cyc(3);

    req = "R2"; mode_cfg = 3'b010; wait_cyc(4);
    mode_cfg = 3'b011; pulse_set(); wait_cyc(4);
    mode_cfg = 3'b000; wait_cyc(3);
    pulse_wake(0); wait_cyc(2);

    req = "R3"; mode_cfg = 3'b001; bus_busy = 1'b1; pulse_set(); wait_cyc(4);
    req = "R5"; pulse_wake(0); wait_cyc(2); bus_busy = 1'b0;

    req = "R4"; mode_cfg = 3'b010; bus_busy = 1'b1; pulse_set(); wait_cyc(5);
    bus_busy = 1'b0; wait_cyc(3);
    req = "R5"; pulse_wake(1); wait_cyc(2);

    req = "R4"; mode_cfg = 3'b100; pulse_set(); wait_cyc(4);
    req = "R5"; pulse_wake(2); wait_cyc(2);

    req = "R5"; bus_busy = 1'b1; mode_cfg = 3'b010; pulse_set(); wait_cyc(3);
    pulse_wake(0); bus_busy = 1'b0; wait_cyc(2);

    req = "R6"; mode_cfg = 3'b100; pulse_set(); wait_cyc(3);
    pll_stopped = 1'b1; wait_cyc(2); pulse_wake(0); wait_cyc(4);
    pulse_wake(1); wait_cyc(RELOCK_LEN + 3); pll_stopped = 1'b0;

    req = "R7"; mode_cfg = 3'b001; pow_set = 1'b1; wake_mcp = 1'b1; wait_cyc(1);
    pow_set = 1'b0; wake_mcp = 1'b0; wait_cyc(3);
    pulse_set(); wait_cyc(1); pulse_wake(2); wait_cyc(2);

    req = "R8"; mode_cfg = 3'b010; bus_busy = 1'b1; pulse_set(); wait_cyc(3);
    pulse_soft(); bus_busy = 1'b0; wait_cyc(2);
    mode_cfg = 3'b100; pulse_set(); wait_cyc(3); pulse_soft(); wait_cyc(2);

    req = "R9"; mode_cfg = 3'b010; pulse_set(); wait_cyc(4);
    #2 rst_n = 1'b0; #1;
    check("status async", int'(status), 0);
    check("core_clk_en async", int'(core_clk_en), 1);
    wait_cyc(2); rst_n = 1'b1; wait_cyc(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule